// File: doc/BRIEF.md
# Free-Running Composite Video Sync Generator

This block derives line, field and frame timing for 625-line or 525-line television scanning from a single system clock. It runs with no video input. It drives an active-low composite sync built from normal line pulses, equalizing pulses and broad pulses. It also drives a horizontal pulse, a vertical pulse, a field-identity flag and the current line number within the frame. The only timing parameter is the number of clock ticks per microsecond. Every nominal duration is converted to ticks by rounding to the nearest tick. Each edge is placed relative to the start of its own half-line.

The timebase counts half-lines. Each field opens with a block of equalizing pulses, then a block of broad pulses, then a second block of equalizing pulses. Normal line pulses follow on every line start. A three-bit mode word selects the standard and the scan variant: interlaced, or one of two non-interlaced field lengths. The block samples the mode word only when a frame wraps, so the timing of a frame never changes part-way through it.

Top module: `composite_sync_gen`

## Requirements
- R1: While rst_ni is low, the outputs show line 1 of field 0 at tick 0 in the 625-line interlaced mode: csync_no low, hs_o high, vs_o high, line_o = 1, field_o = 0.
- R2: A half-line lasts 32 µs (625) or 31.8 µs (525), rounded to whole ticks. line_o counts lines from 1 within a frame and advances by one at every line start.
- R3: Outside the field's pulse blocks, csync_no goes low for 4.7 µs from each line start and stays high at mid-line.
- R4: The first and third pulse blocks of a field each hold 5 (625) or 6 (525) half-line equalizing pulses, each low for 2.35 µs (625) or 2.3 µs (525) from its half-line start.
- R5: The middle block holds the same number of broad pulses, each low from its half-line start until 4.7 µs before the half-line ends.
- R6: hs_o is high for 2 µs from each line start and low at all other times.
- R7: vs_o is high for exactly the first two half-lines (one line) of each field.
- R8: mode_i[2] selects the standard (0 = 625 lines, 1 = 525 lines). mode_i[1:0] selects the scan: 0 gives interlaced fields of 312.5 or 262.5 lines, with the second field starting at mid-line. 1 gives fields of 312/312 or 262/262 lines. 2 gives 313/312 or 263/262 lines. 3 acts as 1. field_o is 0 in the first field and 1 in the second.
- R9: mode_i is sampled only on the clock edge that ends the last half-line of a frame. Changes at any other time have no effect until then. Reset selects the 625-line interlaced mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | {standard, scan[1:0]}, taken at frame wrap |
| csync_no | output | 1 | Composite sync, active low |
| hs_o | output | 1 | Horizontal pulse, active high |
| vs_o | output | 1 | Vertical pulse, active high |
| field_o | output | 1 | Field identity, 0 = first field |
| line_o | output | 10 | Line number within the frame, from 1 |

## Verification
The assertions check, on every cycle, a set of structural properties. The tick counter stays within the half-line length of the latched standard. line_o only steps by one or wraps to 1. Every hs_o pulse sits inside a low phase of csync_no. Every field change coincides with vs_o. The latched mode changes only on the first cycle of a frame. The exact pulse widths, the number of pulses in each block, the mid-line start of the interlaced second field, the field lengths of each scan variant, and the rule that mid-frame mode writes are ignored can only be shown by the bench. It compares every output on every cycle of three whole frames in different modes against a tick-by-tick expectation.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic [1:0] {
    SCAN_ILACE  = 2'd0,
    SCAN_EVEN   = 2'd1,
    SCAN_LONG   = 2'd2,
    SCAN_RSVD   = 2'd3
  } scan_e;

  typedef struct packed {
    logic  std525;
    scan_e scan;
  } mode_t;

  // nominal time in hundredths of a microsecond -> nearest tick
  function automatic int unsigned to_ticks(int unsigned tpu, int unsigned hundredths);
    return (tpu * hundredths + 50) / 100;
  endfunction

  // field length in half-lines
  function automatic int unsigned field_halves(mode_t m, logic second);
    int unsigned base;
    base = m.std525 ? 524 : 624;
    case (m.scan)
      SCAN_ILACE: return base + 1;
      SCAN_LONG:  return second ? base : base + 2;
      default:    return base;
    endcase
  endfunction

endpackage

// File: rtl/cs_timebase.sv
module cs_timebase #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned HALF_A = 864,
  parameter int unsigned HALF_B = 859
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_b_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hl_end_o
);

  logic [CNT_W-1:0] last;

  assign last     = sel_b_i ? CNT_W'(HALF_B - 1) : CNT_W'(HALF_A - 1);
  assign hl_end_o = (cnt_o == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (hl_end_o) cnt_o <= '0;
    else               cnt_o <= cnt_o + CNT_W'(1);
  end

endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
  import cs_pkg::*;
#(
  parameter int unsigned HL_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hl_end_i,
  input  mode_t           mode_i,
  output mode_t           mode_q_o,
  output logic [HL_W-1:0] fh_o,
  output logic [HL_W-1:0] fl_o,
  output logic            field_o
);

  logic [HL_W-1:0] f1_len, f2_len, fld_last;
  logic            frame_end, field_end;

  always_comb begin
    f1_len    = HL_W'(field_halves(mode_q_o, 1'b0));
    f2_len    = HL_W'(field_halves(mode_q_o, 1'b1));
    fld_last  = (field_o ? f2_len : f1_len) - HL_W'(1);
    frame_end = (fh_o == f1_len + f2_len - HL_W'(1));
    field_end = (fl_o == fld_last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o <= mode_t'('0);
      fh_o     <= '0;
      fl_o     <= '0;
      field_o  <= 1'b0;
    end else if (hl_end_i) begin
      if (frame_end) begin
        mode_q_o <= mode_i;
        fh_o     <= '0;
        fl_o     <= '0;
        field_o  <= 1'b0;
      end else begin
        fh_o <= fh_o + HL_W'(1);
        if (field_end) begin
          fl_o    <= '0;
          field_o <= 1'b1;
        end else begin
          fl_o <= fl_o + HL_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/cs_pulse.sv
module cs_pulse #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned HL_W     = 11,
  parameter int unsigned LINE_W   = 10,
  parameter int unsigned HALF_625 = 864,
  parameter int unsigned HALF_525 = 859,
  parameter int unsigned LS_T     = 127,
  parameter int unsigned EQ_625   = 63,
  parameter int unsigned EQ_525   = 62,
  parameter int unsigned HS_T     = 54
) (
  input  logic              std525_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [HL_W-1:0]   fh_i,
  input  logic [HL_W-1:0]   fl_i,
  output logic              csync_no,
  output logic              hs_o,
  output logic              vs_o,
  output logic [LINE_W-1:0] line_o
);

  localparam int unsigned BR_625 = HALF_625 - LS_T;
  localparam int unsigned BR_525 = HALF_525 - LS_T;

  logic [HL_W-1:0]  grp;
  logic [CNT_W-1:0] eq_t, br_t;
  logic             line_start, low;

  always_comb begin
    grp        = std525_i ? HL_W'(6) : HL_W'(5);
    eq_t       = std525_i ? CNT_W'(EQ_525) : CNT_W'(EQ_625);
    br_t       = std525_i ? CNT_W'(BR_525) : CNT_W'(BR_625);
    line_start = ~fh_i[0];
    if (fl_i < grp || (fl_i >= 2 * grp && fl_i < 3 * grp))
      low = cnt_i < eq_t;
    else if (fl_i < 2 * grp)
      low = cnt_i < br_t;
    else
      low = line_start && (cnt_i < CNT_W'(LS_T));
  end

  assign csync_no = ~low;
  assign hs_o     = line_start && (cnt_i < CNT_W'(HS_T));
  assign vs_o     = (fl_i < HL_W'(2));
  assign line_o   = LINE_W'(fh_i >> 1) + LINE_W'(1);

endmodule

// File: rtl/composite_sync_gen.sv
module composite_sync_gen
  import cs_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 27
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  output logic       csync_no,
  output logic       hs_o,
  output logic       vs_o,
  output logic       field_o,
  output logic [9:0] line_o
);

  localparam int unsigned HL_W     = 11;
  localparam int unsigned LINE_W   = HL_W - 1;
  localparam int unsigned HALF_625 = to_ticks(TICKS_PER_US, 3200);
  localparam int unsigned HALF_525 = to_ticks(TICKS_PER_US, 3180);
  localparam int unsigned LS_T     = to_ticks(TICKS_PER_US, 470);
  localparam int unsigned EQ_625   = to_ticks(TICKS_PER_US, 235);
  localparam int unsigned EQ_525   = to_ticks(TICKS_PER_US, 230);
  localparam int unsigned HS_T     = to_ticks(TICKS_PER_US, 200);
  localparam int unsigned CNT_W    = $clog2(HALF_625 + 1);

  mode_t            mode_q;
  logic [CNT_W-1:0] cnt;
  logic             hl_end;
  logic [HL_W-1:0]  fh, fl;

  cs_timebase #(
    .CNT_W (CNT_W),
    .HALF_A(HALF_625),
    .HALF_B(HALF_525)
  ) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_b_i (mode_q.std525),
    .cnt_o   (cnt),
    .hl_end_o(hl_end)
  );

  cs_sequencer #(
    .HL_W(HL_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hl_end_i(hl_end),
    .mode_i  (mode_t'(mode_i)),
    .mode_q_o(mode_q),
    .fh_o    (fh),
    .fl_o    (fl),
    .field_o (field_o)
  );

  cs_pulse #(
    .CNT_W   (CNT_W),
    .HL_W    (HL_W),
    .LINE_W  (LINE_W),
    .HALF_625(HALF_625),
    .HALF_525(HALF_525),
    .LS_T    (LS_T),
    .EQ_625  (EQ_625),
    .EQ_525  (EQ_525),
    .HS_T    (HS_T)
  ) u_pls (
    .std525_i(mode_q.std525),
    .cnt_i   (cnt),
    .fh_i    (fh),
    .fl_i    (fl),
    .csync_no(csync_no),
    .hs_o    (hs_o),
    .vs_o    (vs_o),
    .line_o  (line_o)
  );

endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned HALF_625 = 864,
  parameter int unsigned HALF_525 = 859
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csync_no,
  input logic             hs_o,
  input logic             vs_o,
  input logic             field_o,
  input logic [9:0]       line_o,
  input logic [CNT_W-1:0] cnt,
  input logic             hl_end,
  input logic [2:0]       mode_q
);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < (mode_q[2] ? CNT_W'(HALF_525) : CNT_W'(HALF_625))); // R2

  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> (line_o == $past(line_o) + 10'd1) || (line_o == 10'd1)); // R2

  AST_HS_IN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_o |-> !csync_no); // R6

  AST_FIELD_VS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_o) |-> vs_o); // R7

  AST_MODE_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> (line_o == 10'd1) && !field_o && $past(hl_end)); // R9

endmodule

bind composite_sync_gen cs_checker #(
  .CNT_W   (CNT_W),
  .HALF_625(HALF_625),
  .HALF_525(HALF_525)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .csync_no(csync_no),
  .hs_o    (hs_o),
  .vs_o    (vs_o),
  .field_o (field_o),
  .line_o  (line_o),
  .cnt     (cnt),
  .hl_end  (hl_end),
  .mode_q  (mode_q)
);

// File: tb/sim_composite_sync_gen.sv
`timescale 1ns/1ps
module sim_composite_sync_gen;

  // one tick per microsecond: half-line 32, line sync 5, equalizing 2,
  // broad low 27, hs 2 ticks (nearest-tick rounding, both standards)
  localparam int HALF = 32;
  localparam int LS   = 5;
  localparam int EQ   = 2;
  localparam int BR   = 27;
  localparam int HSW  = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [2:0] mode_i;
  logic       csync_no, hs_o, vs_o, field_o;
  logic [9:0] line_o;

  always #2 clk_i = ~clk_i;

  composite_sync_gen #(.TICKS_PER_US(1)) u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .csync_no(csync_no),
    .hs_o    (hs_o),
    .vs_o    (vs_o),
    .field_o (field_o),
    .line_o  (line_o)
  );

  typedef struct {
    logic       cs;
    logic       hs;
    logic       vs;
    logic [9:0] line;
    logic       fld;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: expected outputs of one whole frame, one item per cycle
  task automatic push_frame(input logic [2:0] m);
    int grp, base, f1, f2, fh;
    grp  = m[2] ? 6 : 5;
    base = m[2] ? 524 : 624;
    case (m[1:0])
      2'd0:    begin f1 = base + 1; f2 = base + 1; end // R8 interlaced
      2'd2:    begin f1 = base + 2; f2 = base;     end // R8 long/short
      default: begin f1 = base;     f2 = base;     end // R8 equal
    endcase
    fh = 0;
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < (f ? f2 : f1); k++) begin
        for (int t = 0; t < HALF; t++) begin
          exp_t it;
          logic low;
          if (k < grp || (k >= 2 * grp && k < 3 * grp)) begin
            low = (t < EQ); it.tag = "R4 equalizing";
          end else if (k < 2 * grp) begin
            low = (t < BR); it.tag = "R5 broad";
          end else begin
            low = (fh % 2 == 0) && (t < LS); it.tag = "R3 line sync";
          end
          it.cs   = !low;
          it.hs   = (fh % 2 == 0) && (t < HSW);
          it.vs   = (k < 2);
          it.line = 10'(fh / 2 + 1);
          it.fld  = 1'(f);
          q.push_back(it);
          @(negedge clk_i);
        end
        fh++;
      end
    end
  endtask

  // monitor: compare one item per cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        chk(it.tag, csync_no, it.cs);
        chk("R6 hs", hs_o, it.hs);
        chk("R7 vs", vs_o, it.vs);
        chk("R2 line", line_o, it.line);
        chk("R8 field", field_o, it.fld);
      end
    end
  end

  // mid-frame mode writes; only the value present at a wrap counts (R9)
  initial begin
    mode_i = 3'b000;
    wait (rst_ni === 1'b1);
    repeat (10000) @(negedge clk_i);
    mode_i = 3'b010;
    repeat (10000) @(negedge clk_i);
    mode_i = 3'b110;
    repeat (35000) @(negedge clk_i);
    mode_i = 3'b001;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 csync in reset", csync_no, 0);
    chk("R1 hs in reset", hs_o, 1);
    chk("R1 vs in reset", vs_o, 1);
    chk("R1 line in reset", line_o, 1);
    chk("R1 field in reset", field_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    push_frame(3'b000); // R9 reset mode: 625 interlaced
    push_frame(3'b110); // R9 value present at first wrap: 525, 263/262
    push_frame(3'b001); // R9 value present at second wrap: 625, 312/312
    #2;
    chk("R9 queue drained", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule